// File: doc/BRIEF.md
# Bus-Width Matching Port Adapter

This block sits between one port of a 36-bit-wide memory and external logic that can be 36, 18 or 9 bits wide. The memory word is treated as four 9-bit lanes, numbered 0 (bits 8:0) to 3 (bits 35:27). Two static configuration pins choose the external width. Two lane-address pins choose the lane, or pair of lanes, that a narrow transfer reaches.

On a write, the adapter places the low external data bits into the chosen lanes and raises only those lanes' write enables toward the memory. Lanes that are not chosen keep their stored contents. On a read, it takes the chosen lanes from the memory word and returns them on the low external pins, with zeros on the unused upper pins. The returned value is captured in a register and held until the next read.

The width selection is registered. A transfer therefore always uses the width that was present on the configuration pins one clock earlier.

Top module: `busmatch_adapter`

## Requirements
- R1: While reset is active and on the first cycle after it, `ext_rdata` is zero, `ext_rvalid` is 0 and `mem_we` is all zero.
- R2: Width code {cfg_bm,cfg_size}=00 selects 36-bit mode. A write in this mode enables all four lanes and copies `ext_wdata` unchanged to `mem_wdata`, whatever the values of `sel_word` and `sel_byte`.
- R3: A read in 36-bit mode returns the full memory word on `ext_rdata`, whatever the values of `sel_word` and `sel_byte`.
- R4: Width code 01 selects 18-bit mode. A write puts `ext_wdata[17:0]` into lanes 3:2 (bits 35:18) when `sel_word`=0, or into lanes 1:0 when `sel_word`=1. Only those two lanes are enabled, and `sel_byte` is ignored.
- R5: A read in 18-bit mode returns the half chosen by `sel_word` (0 gives bits 35:18, 1 gives bits 17:0) on `ext_rdata[17:0]`, with bits 35:18 zero. `sel_byte` is ignored.
- R6: Width codes 10 and 11 both select 9-bit mode. {sel_word,sel_byte} = 00, 01, 10, 11 choose lane 3, 2, 1, 0 respectively. A write puts `ext_wdata[8:0]` into that lane and enables only that lane.
- R7: A read in 9-bit mode returns the chosen lane on `ext_rdata[8:0]`, with bits 35:9 zero.
- R8: Lanes whose write enable is low keep their stored contents. A narrow write changes no other lane of the word.
- R9: A transfer is sampled at a rising edge, and its outputs change at that same edge. `mem_we` and `mem_wdata` last for one cycle. `ext_rdata` holds its value until the next read, and `ext_rvalid` pulses for one cycle.
- R10: A transfer sampled at edge E uses the width code sampled at edge E-1. A code that changes in the same cycle as a transfer does not affect that transfer.
- R11: In a cycle without `ext_wr`, `mem_we` is all zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bm | input | 1 | Width code, upper bit |
| cfg_size | input | 1 | Width code, lower bit |
| sel_word | input | 1 | Half select (18-bit mode), upper lane-address bit (9-bit mode) |
| sel_byte | input | 1 | Lower lane-address bit (9-bit mode) |
| ext_wr | input | 1 | Write request |
| ext_rd | input | 1 | Read request |
| ext_wdata | input | 36 | External write data |
| ext_rdata | output | 36 | Registered external read data |
| ext_rvalid | output | 1 | One-cycle pulse when ext_rdata has been updated |
| mem_we | output | 4 | Per-lane write enables toward the memory |
| mem_wdata | output | 36 | Lane-steered write data toward the memory |
| mem_rdata | input | 36 | Current memory word |

## Verification
The assertions assume that the memory word on `mem_rdata` is valid in the cycle a read is sampled. They also assume that `ext_wr` and `ext_rd` are never asserted together. The assertions track the width code themselves, one cycle delayed, and check nothing until one edge after reset so that this delayed copy is valid. The stimulus drives each transfer alone, follows every write with an idle cycle so that the bench memory model settles before a read, and changes the width code together with a transfer only in the one case that tests R10.

// File: rtl/busmatch_pkg.sv
package busmatch_pkg;

    localparam int unsigned LANE_COUNT = 4;

    typedef enum logic [1:0] {
        BW_FULL = 2'd0,
        BW_HALF = 2'd1,
        BW_LANE = 2'd2
    } bus_width_e;

endpackage

// File: rtl/bm_mode_decode.sv
module bm_mode_decode
    import busmatch_pkg::*;
(
    input  logic       bm,
    input  logic       size,
    output bus_width_e mode
);

    always_comb begin
        unique case ({bm, size})
            2'b00:   mode = BW_FULL;
            2'b01:   mode = BW_HALF;
            default: mode = BW_LANE;
        endcase
    end

endmodule

// File: rtl/bm_lane_select.sv
module bm_lane_select
    import busmatch_pkg::*;
(
    input  bus_width_e            mode,
    input  logic                  sel_word,
    input  logic                  sel_byte,
    output logic [LANE_COUNT-1:0] mask
);

    localparam int unsigned HALF_LANES = LANE_COUNT / 2;

    logic [1:0] lane_addr;
    assign lane_addr = {sel_word, sel_byte};

    for (genvar i = 0; i < LANE_COUNT; i++) begin : g_lane
        localparam int unsigned IN_UPPER = (i >= HALF_LANES) ? 1 : 0;
        localparam logic [1:0]  MY_ADDR  = 2'(LANE_COUNT - 1 - i);

        logic half_hit;
        logic lane_hit;

        assign half_hit = (IN_UPPER == 1) ? !sel_word : sel_word;
        assign lane_hit = (lane_addr == MY_ADDR);

        always_comb begin
            unique case (mode)
                BW_FULL: mask[i] = 1'b1;
                BW_HALF: mask[i] = half_hit;
                default: mask[i] = lane_hit;
            endcase
        end
    end

endmodule

// File: rtl/bm_write_steer.sv
module bm_write_steer
    import busmatch_pkg::*;
#(
    parameter int unsigned LANE_W = 9
) (
    input  bus_width_e                     mode,
    input  logic [LANE_COUNT-1:0]          mask,
    input  logic [LANE_W*LANE_COUNT-1:0]   ext_wdata,
    output logic [LANE_W*LANE_COUNT-1:0]   lane_wdata
);

    localparam int unsigned HALF_LANES = LANE_COUNT / 2;

    for (genvar i = 0; i < LANE_COUNT; i++) begin : g_lane
        localparam int unsigned HALF_SRC = i % HALF_LANES;

        logic [LANE_W-1:0] src;

        always_comb begin
            unique case (mode)
                BW_FULL: src = ext_wdata[i*LANE_W +: LANE_W];
                BW_HALF: src = ext_wdata[HALF_SRC*LANE_W +: LANE_W];
                default: src = ext_wdata[0 +: LANE_W];
            endcase
        end

        assign lane_wdata[i*LANE_W +: LANE_W] = mask[i] ? src : '0;
    end

endmodule

// File: rtl/bm_read_steer.sv
module bm_read_steer
    import busmatch_pkg::*;
#(
    parameter int unsigned LANE_W = 9
) (
    input  bus_width_e                     mode,
    input  logic [LANE_COUNT-1:0]          mask,
    input  logic [LANE_W*LANE_COUNT-1:0]   mem_rdata,
    output logic [LANE_W*LANE_COUNT-1:0]   ext_data
);

    localparam int unsigned HALF_LANES = LANE_COUNT / 2;

    logic [LANE_W*LANE_COUNT-1:0] gated;

    for (genvar k = 0; k < LANE_COUNT; k++) begin : g_gate
        assign gated[k*LANE_W +: LANE_W] =
            mask[k] ? mem_rdata[k*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        logic [LANE_W-1:0] any_lane;
        any_lane = '0;
        for (int k = 0; k < LANE_COUNT; k++) begin
            any_lane = any_lane | gated[k*LANE_W +: LANE_W];
        end

        ext_data = '0;
        unique case (mode)
            BW_FULL: ext_data = mem_rdata;
            BW_HALF: begin
                for (int j = 0; j < HALF_LANES; j++) begin
                    ext_data[j*LANE_W +: LANE_W] =
                        gated[j*LANE_W +: LANE_W] |
                        gated[(j+HALF_LANES)*LANE_W +: LANE_W];
                end
            end
            default: ext_data[0 +: LANE_W] = any_lane;
        endcase
    end

endmodule

// File: rtl/busmatch_adapter.sv
module busmatch_adapter
    import busmatch_pkg::*;
#(
    parameter int unsigned LANE_W = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_bm,
    input  logic                          cfg_size,
    input  logic                          sel_word,
    input  logic                          sel_byte,
    input  logic                          ext_wr,
    input  logic                          ext_rd,
    input  logic [LANE_W*LANE_COUNT-1:0]  ext_wdata,
    output logic [LANE_W*LANE_COUNT-1:0]  ext_rdata,
    output logic                          ext_rvalid,
    output logic [LANE_COUNT-1:0]         mem_we,
    output logic [LANE_W*LANE_COUNT-1:0]  mem_wdata,
    input  logic [LANE_W*LANE_COUNT-1:0]  mem_rdata
);

    localparam int unsigned DATA_W = LANE_W * LANE_COUNT;

    typedef struct packed {
        bus_width_e             mode;
        logic [LANE_COUNT-1:0]  we;
        logic [DATA_W-1:0]      wdata;
        logic [DATA_W-1:0]      rdata;
        logic                   rvalid;
    } adapter_state_t;

    adapter_state_t st_d, st_q;

    bus_width_e            mode_req;
    logic [LANE_COUNT-1:0] lane_mask;
    logic [DATA_W-1:0]     steered_w;
    logic [DATA_W-1:0]     steered_r;

    bm_mode_decode u_decode (
        .bm   (cfg_bm),
        .size (cfg_size),
        .mode (mode_req)
    );

    bm_lane_select u_select (
        .mode     (st_q.mode),
        .sel_word (sel_word),
        .sel_byte (sel_byte),
        .mask     (lane_mask)
    );

    bm_write_steer #(.LANE_W(LANE_W)) u_wsteer (
        .mode       (st_q.mode),
        .mask       (lane_mask),
        .ext_wdata  (ext_wdata),
        .lane_wdata (steered_w)
    );

    bm_read_steer #(.LANE_W(LANE_W)) u_rsteer (
        .mode      (st_q.mode),
        .mask      (lane_mask),
        .mem_rdata (mem_rdata),
        .ext_data  (steered_r)
    );

    always_comb begin
        st_d        = st_q;
        st_d.mode   = mode_req;
        st_d.we     = '0;
        st_d.rvalid = 1'b0;
        if (ext_wr) begin
            st_d.we    = lane_mask;
            st_d.wdata = steered_w;
        end
        if (ext_rd) begin
            st_d.rdata  = steered_r;
            st_d.rvalid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode   <= BW_FULL;
            st_q.we     <= '0;
            st_q.wdata  <= '0;
            st_q.rdata  <= '0;
            st_q.rvalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_rdata  = st_q.rdata;
    assign ext_rvalid = st_q.rvalid;
    assign mem_we     = st_q.we;
    assign mem_wdata  = st_q.wdata;

endmodule

// File: rtl/busmatch_adapter_chk.sv
module busmatch_adapter_chk
    import busmatch_pkg::*;
#(
    parameter int unsigned LANE_W = 9
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_bm,
    input logic                          cfg_size,
    input logic                          ext_wr,
    input logic                          ext_rd,
    input logic [LANE_W*LANE_COUNT-1:0]  ext_wdata,
    input logic [LANE_W*LANE_COUNT-1:0]  ext_rdata,
    input logic [LANE_COUNT-1:0]         mem_we,
    input logic [LANE_W*LANE_COUNT-1:0]  mem_wdata,
    input logic [LANE_W*LANE_COUNT-1:0]  mem_rdata
);

    logic [1:0] cfg_prev_q;
    logic       armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_prev_q <= 2'b00;
            armed_q    <= 1'b0;
        end else begin
            cfg_prev_q <= {cfg_bm, cfg_size};
            armed_q    <= 1'b1;
        end
    end

    assert_idle_no_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr |=> (mem_we == '0));

    assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ext_wr && cfg_prev_q == 2'b00) |=>
            (mem_we == '1 && mem_wdata == $past(ext_wdata)));

    assert_half_two_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ext_wr && cfg_prev_q == 2'b01) |=> ($countones(mem_we) == 2));

    assert_lane_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ext_wr && cfg_prev_q[1]) |=> ($countones(mem_we) == 1));

    assert_full_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ext_rd && cfg_prev_q == 2'b00) |=> (ext_rdata == $past(mem_rdata)));

    assert_lane_read_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ext_rd && cfg_prev_q[1]) |=> (ext_rdata[LANE_W*LANE_COUNT-1:LANE_W] == '0));

    assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd |=> $stable(ext_rdata));

endmodule

bind busmatch_adapter busmatch_adapter_chk #(.LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_bm    (cfg_bm),
    .cfg_size  (cfg_size),
    .ext_wr    (ext_wr),
    .ext_rd    (ext_rd),
    .ext_wdata (ext_wdata),
    .ext_rdata (ext_rdata),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
);

// File: tb/busmatch_adapter_tb.sv
module busmatch_adapter_tb;

    localparam int LW = 9;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_bm = 1'b0, cfg_size = 1'b0;
    logic          sel_word = 1'b0, sel_byte = 1'b0;
    logic          ext_wr = 1'b0, ext_rd = 1'b0;
    logic [DW-1:0] ext_wdata = '0;
    logic [DW-1:0] ext_rdata;
    logic          ext_rvalid;
    logic [3:0]    mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_word = '0;

    always #2 clk = ~clk;

    busmatch_adapter #(.LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bm(cfg_bm), .cfg_size(cfg_size),
        .sel_word(sel_word), .sel_byte(sel_byte), .ext_wr(ext_wr), .ext_rd(ext_rd),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_rvalid(ext_rvalid),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_word)
    );

    // simple one-word memory behind the port
    always @(posedge clk) begin
        for (int i = 0; i < 4; i++)
            if (mem_we[i]) mem_word[i*LW +: LW] <= mem_wdata[i*LW +: LW];
    end

    typedef struct {
        string         req;
        bit            is_read;
        logic [DW-1:0] data;
        logic [3:0]    we;
    } exp_t;

    exp_t          sb[$];
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 0;
    logic [DW-1:0] shadow = '0;
    logic [DW-1:0] last_read = '0;

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // width: 0 full, 1 half, 2 lane
    function automatic logic [3:0] lanes_of(int w, logic wa, logic ba);
        if (w == 0) return 4'b1111;
        if (w == 1) return wa ? 4'b0011 : 4'b1100;
        return 4'b0001 << (3 - int'({wa, ba}));
    endfunction

    function automatic logic [DW-1:0] lane_bits(logic [3:0] m);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < 4; i++) if (m[i]) r[i*LW +: LW] = '1;
        return r;
    endfunction

    function automatic logic [DW-1:0] placed(int w, logic [3:0] m, logic [DW-1:0] d);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            if (m[i]) begin
                if (w == 0)      r[i*LW +: LW] = d[i*LW +: LW];
                else if (w == 1) r[i*LW +: LW] = d[(i%2)*LW +: LW];
                else             r[i*LW +: LW] = d[LW-1:0];
            end
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] read_exp(int w, logic wa, logic ba, logic [DW-1:0] word);
        if (w == 0) return word;
        if (w == 1) return wa ? {18'b0, word[17:0]} : {18'b0, word[35:18]};
        return {27'b0, word[(3 - int'({wa, ba}))*LW +: LW]};
    endfunction

    // driver: w_eff is the width in force for this transfer
    task automatic do_write(string req, int w_eff, logic bm, logic sz,
                            logic wa, logic ba, logic [DW-1:0] d);
        exp_t e;
        logic [3:0] m;
        @(negedge clk);
        cfg_bm = bm; cfg_size = sz; sel_word = wa; sel_byte = ba;
        ext_wdata = d; ext_wr = 1'b1;
        m = lanes_of(w_eff, wa, ba);
        e.req = req; e.is_read = 0; e.we = m; e.data = placed(w_eff, m, d);
        shadow = (shadow & ~lane_bits(m)) | e.data;
        sb.push_back(e);
        @(negedge clk);
        ext_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(string req, int w_eff, logic bm, logic sz, logic wa, logic ba);
        exp_t e;
        @(negedge clk);
        cfg_bm = bm; cfg_size = sz; sel_word = wa; sel_byte = ba; ext_rd = 1'b1;
        e.req = req; e.is_read = 1; e.we = '0; e.data = read_exp(w_eff, wa, ba, shadow);
        last_read = e.data;
        sb.push_back(e);
        @(negedge clk);
        ext_rd = 1'b0;
    endtask

    task automatic set_cfg(logic bm, logic sz);
        @(negedge clk);
        cfg_bm = bm; cfg_size = sz;
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && (ext_rvalid || mem_we != '0)) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 unexpected output actual we=%b rvalid=%b expected none",
                         mem_we, ext_rvalid);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_read) begin
                    check({e.req, " rvalid"}, {35'b0, ext_rvalid}, 36'd1);
                    check({e.req, " rdata"}, ext_rdata, e.data);
                end else begin
                    check({e.req, " we"}, {32'b0, mem_we}, {32'b0, e.we});
                    check({e.req, " wdata"}, mem_wdata & lane_bits(e.we), e.data);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata", ext_rdata, '0);
        check("R1 rvalid", {35'b0, ext_rvalid}, '0);
        check("R1 we", {32'b0, mem_we}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 we after release", {32'b0, mem_we}, '0);
        check("R11 idle", {32'b0, mem_we}, '0);

        // full width, lane address ignored
        do_write("R2 full write", 0, 0, 0, 1, 0, 36'h9_1234_5678);
        do_read ("R3 full read",  0, 0, 0, 1, 1);
        do_write("R2 full write b", 0, 0, 0, 0, 1, 36'hA_BCDE_F012);
        do_read ("R3 full read b", 0, 0, 0, 0, 0);

        // half width
        set_cfg(0, 1);
        do_write("R4 half upper", 1, 0, 1, 0, 1, 36'hF_FFFC_1234);
        do_read ("R5 half upper", 1, 0, 1, 0, 0);
        do_read ("R8 half lower kept", 1, 0, 1, 1, 1);
        do_write("R4 half lower", 1, 0, 1, 1, 0, 36'h5_5552_BEEF);
        do_read ("R5 half lower", 1, 0, 1, 1, 1);
        do_read ("R8 half upper kept", 1, 0, 1, 0, 1);

        // byte width, both codes
        set_cfg(1, 0);
        do_write("R6 lane3", 2, 1, 0, 0, 0, 36'hF_FFFF_FE11);
        do_write("R6 lane2", 2, 1, 0, 0, 1, 36'h0_0000_0122);
        do_write("R6 lane1", 2, 1, 0, 1, 0, 36'h0_0000_0033);
        do_read ("R7 lane2", 2, 1, 0, 0, 1);
        set_cfg(1, 1);
        do_write("R6 lane0 code11", 2, 1, 1, 1, 1, 36'h7_0000_01C4);
        do_read ("R7 lane0", 2, 1, 1, 1, 1);
        do_read ("R7 lane3", 2, 1, 1, 0, 0);
        set_cfg(0, 0);
        do_read ("R8 full after lanes", 0, 0, 0, 0, 0);

        // width code changes in the same cycle as a transfer
        do_write("R10 old width kept", 0, 1, 0, 1, 1, 36'h1_2345_6789);
        do_read ("R10 new width used", 2, 1, 0, 1, 0);
        set_cfg(0, 0);
        do_read ("R10 full check", 0, 0, 0, 0, 0);

        // read data held across idle cycles and a write
        do_write("R9 write while held", 0, 0, 0, 0, 0, 36'h0_0F0F_0F0F);
        repeat (2) @(negedge clk);
        check("R9 hold", ext_rdata, last_read);
        check("R11 idle after", {32'b0, mem_we}, '0);
        check("R9 scoreboard drained", 36'(sb.size()), '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule